// File: doc/BRIEF.md
# Vectored Interrupt Handshake Controller

This block collects interrupt events from a small set of peripheral sources, such as a front-panel key scanner or a function selector, and presents them to a simple processor. Each source flags an event with a one-cycle strobe, and the event is held pending until it is serviced. While the processor's interrupt-enable input is high and at least one event is pending, the block drives a single request line.

The processor answers with a short acknowledge pulse. For the whole pulse, the block drives a vector that names the source being serviced and places that source's control byte on a data output. Outside the pulse both outputs read zero. When the pulse ends, the pending flag of the serviced source is cleared and all other pending flags are kept. The processor drops its enable input during service, so a second interrupt cannot nest. Event capture stays armed the whole time, so no event is lost while service is under way.

Top module: `vic_ctrl`

## Requirements
- R1: During reset and directly after it, no event is pending: `int_req`, `vec` and `ack_data` are all zero.
- R2: A strobe on `src_event[i]` marks source i pending from the next clock edge. While `int_en` is 1, `int_req` is 1 in the cycle after the strobe.
- R3: `int_req` is 0 in every cycle in which `int_en` is 0, whether or not events are pending.
- R4: On the first cycle of an acknowledge pulse (`int_ack` 1 after a cycle at 0), the pending source with the lowest index is chosen. `vec` carries that index as an unsigned binary number for the whole pulse. Events that arrive during the pulse do not change `vec`.
- R5: While `int_ack` is 1 and a source was chosen, `ack_data` equals bits [i*DATA_W +: DATA_W] of `src_data`, where i is the chosen source. While `int_ack` is 0, both `vec` and `ack_data` are zero.
- R6: In the cycle in which `int_ack` returns to 0, the chosen source's pending flag is cleared at the clock edge. All other pending flags keep their value.
- R7: If the chosen source strobes `src_event` in the same cycle in which its flag is cleared, the flag stays set.
- R8: Events that arrive while `int_en` is 0 are held. `int_req` rises in the first cycle in which `int_en` is 1 again.
- R9: An acknowledge pulse that begins with nothing pending leaves `vec` and `ack_data` at zero for the whole pulse and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_event | input | NUM_SRC | One-cycle event strobe per source |
| src_data | input | NUM_SRC*DATA_W | Control byte of each source, source i at bits [i*DATA_W +: DATA_W] |
| int_en | input | 1 | Interrupt enable from the processor |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec | output | VEC_W | Index of the serviced source, valid only while `int_ack` is 1 |
| ack_data | output | DATA_W | Control byte of the serviced source, valid only while `int_ack` is 1 |

## Verification
The hardest case to reach from the ports is an event from the serviced source that lands in exactly the cycle in which the acknowledge falls. A directed sequence sets up a single pending source, holds the acknowledge for two cycles and strobes that source in the falling cycle. Lower-index events that arrive in the middle of a pulse, and pulses that begin with nothing pending, are also placed by directed sequences. After that, a seeded random run of sparse events, random-length pulses and enable toggles is checked cycle by cycle against a bench model.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
   // Width of a source index; never narrower than one bit.
   function automatic int vec_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
// Lowest set index wins.
module vic_prio #(
   parameter  int NUM_SRC = 4,
   localparam int VW      = vic_pkg::vec_width(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic [VW-1:0]      idx_o,
   output logic               any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = VW'(i);
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/vic_pend_bank.sv
`timescale 1ns/1ps
// One sticky flag per source; a set wins over a clear in the same cycle.
module vic_pend_bank #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend_o[g] <= 1'b0;
         else if (set_i[g]) pend_o[g] <= 1'b1;
         else if (clr_i[g]) pend_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/vic_ack_track.sv
`timescale 1ns/1ps
// Follows the acknowledge pulse and holds the source chosen at its start.
module vic_ack_track #(
   parameter  int NUM_SRC = 4,
   localparam int VW      = vic_pkg::vec_width(NUM_SRC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack_i,
   input  logic [VW-1:0] cand_idx_i,
   input  logic          cand_any_i,
   output logic          ack_q_o,
   output logic          fall_o,
   output logic [VW-1:0] cur_idx_o,
   output logic          cur_vld_o,
   output logic [VW-1:0] win_idx_o,
   output logic          win_vld_o
);
   logic rise;

   assign rise   = ack_i & ~ack_q_o;
   assign fall_o = ~ack_i & ack_q_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q_o   <= 1'b0;
         win_idx_o <= '0;
         win_vld_o <= 1'b0;
      end else begin
         ack_q_o <= ack_i;
         if (rise) begin
            win_idx_o <= cand_idx_i;
            win_vld_o <= cand_any_i;
         end
      end
   end

   // On the first pulse cycle the choice is taken straight from the encoder.
   assign cur_idx_o = rise ? cand_idx_i : win_idx_o;
   assign cur_vld_o = rise ? cand_any_i : win_vld_o;
endmodule

// File: rtl/vic_ctrl.sv
`timescale 1ns/1ps
module vic_ctrl #(
   parameter  int NUM_SRC = 4,
   parameter  int DATA_W  = 8,
   localparam int VEC_W   = vic_pkg::vec_width(NUM_SRC)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          src_event,
   input  logic [NUM_SRC*DATA_W-1:0]   src_data,
   input  logic                        int_en,
   input  logic                        int_ack,
   output logic                        int_req,
   output logic [VEC_W-1:0]            vec,
   output logic [DATA_W-1:0]           ack_data
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("vic_ctrl: NUM_SRC must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("vic_ctrl: DATA_W must be at least 1");
   end

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] clr;
   logic [VEC_W-1:0]   cand_idx, cur_idx, win_q;
   logic               cand_any, cur_vld, win_vld_q, ack_q, fall;
   logic               show;

   vic_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(src_event), .clr_i(clr), .pend_o(pend_q)
   );

   vic_prio #(.NUM_SRC(NUM_SRC)) u_prio (
      .req_i(pend_q), .idx_o(cand_idx), .any_o(cand_any)
   );

   vic_ack_track #(.NUM_SRC(NUM_SRC)) u_track (
      .clk(clk), .rst_n(rst_n), .ack_i(int_ack),
      .cand_idx_i(cand_idx), .cand_any_i(cand_any),
      .ack_q_o(ack_q), .fall_o(fall),
      .cur_idx_o(cur_idx), .cur_vld_o(cur_vld),
      .win_idx_o(win_q), .win_vld_o(win_vld_q)
   );

   always_comb begin
      clr = '0;
      if (fall && win_vld_q) clr[win_q] = 1'b1;
   end

   assign show     = int_ack & cur_vld;
   assign int_req  = int_en & (|pend_q);
   assign vec      = show ? cur_idx : '0;
   assign ack_data = show ? src_data[cur_idx*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/vic_ctrl_chk.sv
`timescale 1ns/1ps
module vic_ctrl_chk #(
   parameter  int NUM_SRC = 4,
   parameter  int DATA_W  = 8,
   localparam int VEC_W   = vic_pkg::vec_width(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_event,
   input logic               int_en,
   input logic               int_ack,
   input logic               int_req,
   input logic [VEC_W-1:0]   vec,
   input logic [DATA_W-1:0]  ack_data,
   input logic [NUM_SRC-1:0] pend,
   input logic               ack_q,
   input logic               fall,
   input logic [VEC_W-1:0]   win,
   input logic               win_vld
);
   // R3
   p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> !int_req);

   // R2
   p_req_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_event != '0) |=> (int_req || !int_en));

   // R5
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ack |-> (vec == '0 && ack_data == '0));

   // R4
   p_vec_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && ack_q) |-> $stable(vec));

   // R6
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && win_vld && !src_event[win]) |=> !pend[win]);

   // R7
   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && win_vld && src_event[win]) |=> pend[win]);
endmodule

bind vic_ctrl vic_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_event(src_event), .int_en(int_en),
   .int_ack(int_ack), .int_req(int_req), .vec(vec), .ack_data(ack_data),
   .pend(pend_q), .ack_q(ack_q), .fall(fall), .win(win_q), .win_vld(win_vld_q)
);

// File: tb/vic_ctrl_test.sv
`timescale 1ns/1ps
module vic_ctrl_test;
   localparam int N  = 4;
   localparam int DW = 8;
   localparam int VW = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N-1:0]    src_event;
   logic [N*DW-1:0] src_data;
   logic            int_en, int_ack;
   logic            int_req;
   logic [VW-1:0]   vec;
   logic [DW-1:0]   ack_data;

   vic_ctrl #(.NUM_SRC(N), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .src_event(src_event), .src_data(src_data),
      .int_en(int_en), .int_ack(int_ack), .int_req(int_req), .vec(vec),
      .ack_data(ack_data)
   );

   always #2 clk = ~clk;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   // Bench model
   logic [N-1:0]  m_pend;
   logic          m_ack_q;
   logic [VW-1:0] m_win;
   logic          m_vld;

   function automatic logic [VW-1:0] lowest(input logic [N-1:0] p);
      for (int i = 0; i < N; i++) if (p[i]) return VW'(i);
      return '0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic [N-1:0] ev, input logic ack, input logic en);
      logic          rise, fall, cv;
      logic [VW-1:0] ci;
      @(negedge clk);
      src_event = ev;
      int_ack   = ack;
      int_en    = en;
      src_data  = {$urandom, $urandom} [N*DW-1:0];
      #0.5;
      rise = ack && !m_ack_q;
      fall = !ack && m_ack_q;
      ci   = rise ? lowest(m_pend) : m_win;
      cv   = rise ? (m_pend != '0) : m_vld;
      chk(en ? "R2 int_req" : "R3 int_req", 32'(int_req), 32'(en && (m_pend != '0)));
      chk((ack && !cv) ? "R9 vec" : "R4 vec", 32'(vec), (ack && cv) ? 32'(ci) : 0);
      chk("R5 ack_data", 32'(ack_data),
          (ack && cv) ? 32'(src_data[ci*DW +: DW]) : 0);
      @(posedge clk);
      if (rise) begin m_win = ci; m_vld = cv; end
      if (fall && m_vld) m_pend[m_win] = 1'b0;
      m_pend  = m_pend | ev;
      m_ack_q = ack;
   endtask

   task automatic pulse(input int len, input logic en);
      for (int k = 0; k < len; k++) step('0, 1'b1, en);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; src_event = '0; src_data = '0; int_en = 1'b0; int_ack = 1'b0;
      m_pend = '0; m_ack_q = 1'b0; m_win = '0; m_vld = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      int_en = 1'b1;
      #0.5;
      chk("R1 int_req", 32'(int_req), 0);
      chk("R1 vec", 32'(vec), 0);
      chk("R1 ack_data", 32'(ack_data), 0);
      rst_n = 1'b1;
      step('0, 1'b0, 1'b1);
      chk("R1 int_req after reset", 32'(int_req), 0);

      // R9: pulse with nothing pending
      pulse(3, 1'b1);
      step('0, 1'b0, 1'b1);
      chk("R9 nothing cleared, no request", 32'(int_req), 0);

      // R2 / R6: two sources, lowest first, other one kept
      step(4'b0110, 1'b0, 1'b1);
      step('0, 1'b0, 1'b1);
      chk("R2 request raised", 32'(int_req), 1);
      pulse(2, 1'b0);
      step('0, 1'b0, 1'b0);          // falling cycle, clears source 1
      step('0, 1'b0, 1'b1);
      chk("R6 other flag kept", 32'(int_req), 1);
      step('0, 1'b1, 1'b1);
      chk("R6 next vector", 32'(vec), 2);
      step('0, 1'b0, 1'b1);          // clears source 2
      step('0, 1'b0, 1'b1);
      chk("R6 all serviced", 32'(int_req), 0);

      // R7: event of the serviced source on the falling cycle
      step(4'b0100, 1'b0, 1'b1);
      pulse(2, 1'b0);
      step(4'b0100, 1'b0, 1'b0);
      step('0, 1'b0, 1'b1);
      chk("R7 flag survives clear", 32'(int_req), 1);
      pulse(1, 1'b0);
      step('0, 1'b0, 1'b1);
      step('0, 1'b0, 1'b1);
      chk("R7 cleared on later service", 32'(int_req), 0);

      // R4: lower-index event mid-pulse does not change the vector
      step(4'b1000, 1'b0, 1'b1);
      step('0, 1'b1, 1'b0);
      step(4'b0001, 1'b1, 1'b0);
      step('0, 1'b1, 1'b0);
      chk("R4 vector held", 32'(vec), 3);
      step('0, 1'b0, 1'b0);
      step('0, 1'b1, 1'b1);
      chk("R4 new winner next pulse", 32'(vec), 0);
      step('0, 1'b0, 1'b1);

      // R8: events held while disabled
      step(4'b0010, 1'b0, 1'b0);
      step('0, 1'b0, 1'b0);
      chk("R3 gated while disabled", 32'(int_req), 0);
      step('0, 1'b0, 1'b1);
      chk("R8 request on re-enable", 32'(int_req), 1);
      pulse(1, 1'b1);
      step('0, 1'b0, 1'b1);

      // Constrained random
      begin
         logic a = 1'b0;
         for (int t = 0; t < 4000; t++) begin
            logic [N-1:0] ev;
            ev = (($urandom % 6) == 0) ? N'($urandom) : '0;
            if (a) a = ($urandom % 2) == 0;
            else   a = ($urandom % 8) == 0;
            step(ev, a, ($urandom % 5) != 0);
         end
      end

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule